// File: doc/BRIEF.md
# Single Sprite Overlay Generator

This block overlays one 16x16 sprite on a raster picture. A CPU loads the sprite's pixels, its 15 colours, its screen position and its scale factors through a byte-wide write port. The video timing logic presents the current beam coordinates each clock. The block answers with a flag that says the sprite covers that point, and the 12-bit colour to show there.

Each pixel is a 4-bit pen number. Pen 0 is see-through, so the flag stays low and the background shows. Pens 1 to 15 select entries of a palette that belongs to the sprite alone. The sprite can be stretched by 1, 2 or 4 in each direction independently. It can also be hidden through the scale register.

Top module: `sprite_overlay`

## Requirements
- R1: While reset is held, and after it is released with no writes, `hit` is 0 and `colour` is 0.
- R2: A write to address 0x4000 + 16*row + col (row, col in 0..15) sets the pen of that pixel to wr_data[3:0]; wr_data[7:4] has no effect.
- R3: Pen p (1..15) has its colour at two bytes: address 0x6420+2p is colour[7:0], and bits 3:0 of address 0x6421+2p are colour[11:8]; the upper nibble of that second byte has no effect.
- R4: The X position is written low byte at 0x6000, high byte at 0x6001; the Y position is written low byte at 0x6002, high byte at 0x6003.
- R5: Address 0x6004 holds the scale: bits 3:2 are the X code and bits 1:0 the Y code; codes 1, 2, 3 give 1x, 2x, 4x. The column is (beam_x − X) shifted right by (code−1), and the row uses beam_y, Y and the Y code the same way.
- R6: When either scale code is 0, `hit` is 0 and `colour` is 0 at every beam position.
- R7: A beam position left of X or above Y, or whose column or row is above 15, gives `hit` 0 and `colour` 0.
- R8: A pixel with pen 0 gives `hit` 0 and `colour` 0; a pixel with a non-zero pen gives `hit` 1 and that pen's palette colour.
- R9: `hit` and `colour` are registered: they reflect the beam position and state present at the previous rising clock edge, so a new position each cycle gives a new result each cycle.
- R10: Writes to any address outside the pixel range, pens 1..15 of the palette, and 0x6000–0x6004 change nothing, including 0x4100, 0x6420, 0x6421 and 0x6005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 8 | Write byte |
| beam_x | input | 16 | Current beam column |
| beam_y | input | 16 | Current beam line |
| hit | output | 1 | Sprite covers the point given the cycle before |
| colour | output | 12 | Colour of the sprite at that point, 0 when no hit |

## Verification
A wrong pixel or palette entry shows as a wrong colour or a lost flag at exactly the beam positions that map to it, one clock after the beam reaches them. The bench therefore sweeps the whole sprite window and a border around it at every scale setting, so each stored pen and each colour is seen at the ports. A wrong position or scale value moves or resizes the covered rectangle, and the border points expose it on the first line that crosses the edge. A stray write decode corrupts state that the next sweep reads back.

// File: rtl/sprite_overlay.sv
module sprite_overlay #(
  parameter int COORD_W  = 16,
  parameter int SIDE_LOG = 4,
  parameter int COLOUR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [15:0]         wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [COORD_W-1:0]  beam_x,
  input  logic [COORD_W-1:0]  beam_y,
  output logic                hit,
  output logic [COLOUR_W-1:0] colour
);
  localparam int PIX_N = 1 << (2 * SIDE_LOG);
  localparam int PENS  = 16;

  logic [3:0]          pix_mem [PIX_N];
  logic [COLOUR_W-1:0] pal_mem [PENS];
  logic [15:0]         pos_x, pos_y;
  logic [1:0]          mag_x, mag_y;

  wire sel_pix = wr_en && (wr_addr[15:8] == 8'h40);
  wire sel_pal = wr_en && (wr_addr[15:5] == 11'h321) && (wr_addr[4:1] != 4'd0);
  wire sel_reg = wr_en && (wr_addr[15:3] == 13'h0C00);

  always_ff @(posedge clk)
    if (sel_pix) pix_mem[wr_addr[7:0]] <= wr_data[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PENS; i++) pal_mem[i] <= '0;
    end else if (sel_pal) begin
      if (wr_addr[0]) pal_mem[wr_addr[4:1]][11:8] <= wr_data[3:0];
      else            pal_mem[wr_addr[4:1]][7:0]  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_x <= '0;
      pos_y <= '0;
      mag_x <= '0;
      mag_y <= '0;
    end else if (sel_reg) begin
      case (wr_addr[2:0])
        3'd0: pos_x[7:0]  <= wr_data;
        3'd1: pos_x[15:8] <= wr_data;
        3'd2: pos_y[7:0]  <= wr_data;
        3'd3: pos_y[15:8] <= wr_data;
        3'd4: {mag_x, mag_y} <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  logic [COORD_W:0] dx, dy, col, row;
  logic [1:0]       sh_x, sh_y;
  logic             in_x, in_y, shown;
  logic [3:0]       pen;

  assign dx   = {1'b0, beam_x} - {1'b0, pos_x};
  assign dy   = {1'b0, beam_y} - {1'b0, pos_y};
  assign sh_x = mag_x - 2'd1;
  assign sh_y = mag_y - 2'd1;
  assign col  = dx >> sh_x;
  assign row  = dy >> sh_y;
  assign in_x = !dx[COORD_W] && (col[COORD_W:SIDE_LOG] == '0);
  assign in_y = !dy[COORD_W] && (row[COORD_W:SIDE_LOG] == '0);
  assign pen  = pix_mem[{row[SIDE_LOG-1:0], col[SIDE_LOG-1:0]}];
  assign shown = (mag_x != 2'd0) && (mag_y != 2'd0) && in_x && in_y && (pen != 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit    <= 1'b0;
      colour <= '0;
    end else begin
      hit    <= shown;
      colour <= shown ? pal_mem[pen] : '0;
    end
  end

  AST_CLEAR_WHEN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> colour == '0); // R8
  AST_HIDDEN_X: assert property (@(posedge clk) disable iff (!rst_n) (mag_x == 2'd0) |=> !hit); // R6
  AST_HIDDEN_Y: assert property (@(posedge clk) disable iff (!rst_n) (mag_y == 2'd0) |=> !hit); // R6
  AST_LEFT_OF_SPRITE: assert property (@(posedge clk) disable iff (!rst_n) (beam_x < pos_x) |=> !hit); // R7
  AST_ABOVE_SPRITE: assert property (@(posedge clk) disable iff (!rst_n) (beam_y < pos_y) |=> !hit); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!hit && colour == '0)); // R1
endmodule

// File: tb/sprite_overlay_bench.sv
module sprite_overlay_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] beam_x = '0;
  logic [15:0] beam_y = '0;
  logic        hit;
  logic [11:0] colour;

  sprite_overlay u_sprite_overlay (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .beam_x(beam_x), .beam_y(beam_y), .hit(hit), .colour(colour)
  );

  always #5 clk = ~clk;

  int    total = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    done = 0;
  int    q_due[$];
  logic [12:0] q_exp[$];
  string q_tag[$];

  logic [3:0]  m_pix [256];
  logic [11:0] m_pal [16];
  int m_px = 0, m_py = 0, m_mx = 0, m_my = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [12:0] model(int bx, int by);
    int dx, dy, c, r;
    logic [3:0] p;
    if (m_mx == 0 || m_my == 0) return '0;
    dx = bx - m_px;
    dy = by - m_py;
    if (dx < 0 || dy < 0) return '0;
    c = dx >> (m_mx - 1);
    r = dy >> (m_my - 1);
    if (c > 15 || r > 15) return '0;
    p = m_pix[r * 16 + c];
    if (p == 4'd0) return '0;
    return {1'b1, m_pal[p]};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a >= 16'h4000 && a <= 16'h40FF) m_pix[a[7:0]] = d[3:0];
    else if (a >= 16'h6422 && a <= 16'h643F) begin
      if (a[0]) m_pal[a[4:1]][11:8] = d[3:0];
      else      m_pal[a[4:1]][7:0]  = d;
    end
    else if (a == 16'h6000) m_px = (m_px & 16'hFF00) | int'(d);
    else if (a == 16'h6001) m_px = (m_px & 16'h00FF) | (int'(d) << 8);
    else if (a == 16'h6002) m_py = (m_py & 16'hFF00) | int'(d);
    else if (a == 16'h6003) m_py = (m_py & 16'h00FF) | (int'(d) << 8);
    else if (a == 16'h6004) begin m_mx = int'(d[3:2]); m_my = int'(d[1:0]); end
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic probe(input int bx, input int by, input string tag);
    @(negedge clk);
    beam_x = bx[15:0];
    beam_y = by[15:0];
    q_due.push_back(cyc + 1);
    q_exp.push_back(model(bx, by));
    q_tag.push_back(tag);
  endtask

  task automatic sweep(input int x0, input int x1, input int y0, input int y1, input string tag);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) probe(x, y, tag);
  endtask

  task automatic set_pos(input int x, input int y);
    wr(16'h6000, x[7:0]); wr(16'h6001, x[15:8]);
    wr(16'h6002, y[7:0]); wr(16'h6003, y[15:8]);
  endtask

  always @(posedge clk) begin
    #2;
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      logic [12:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      total++;
      if ({hit, colour} !== e) begin
        fails++;
        $display("FAIL %s: hit/colour got %b/%h expected %b/%h", t, hit, colour, e[12], e[11:0]);
      end
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog: run incomplete, got timeout expected finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) m_pix[i] = '0;
    for (int i = 0; i < 16; i++) m_pal[i] = '0;
    repeat (3) @(negedge clk);
    total++;
    if (hit !== 1'b0 || colour !== 12'h000) begin
      fails++;
      $display("FAIL R1: in reset got %b/%h expected 0/000", hit, colour);
    end
    @(negedge clk) rst_n = 1'b1;
    probe(0, 0, "R1");
    probe(5, 7, "R1");

    // R2: pixels with junk in the upper nibble
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        wr(16'h4000 + 16'(r * 16 + c), {4'hA, 4'((c + 3 * r) & 15)});
    // R3: palette with junk in the top nibble of the high byte
    for (int p = 1; p < 16; p++) begin
      logic [11:0] v;
      v = 12'(p * 12'h111) ^ 12'h5A3;
      wr(16'h6420 + 16'(2 * p), v[7:0]);
      wr(16'h6421 + 16'(2 * p), {4'hC, v[11:8]});
    end
    set_pos(100, 50); // R4
    wr(16'h6004, 8'hF5);

    probe(100, 50, "R8");
    probe(101, 50, "R8");
    probe(105, 53, "R4");
    probe(115, 65, "R3");
    sweep(97, 118, 47, 68, "R2");
    for (int i = 0; i < 40; i++) probe((i % 2) ? 103 : 99, 52, "R9");
    probe(116, 55, "R7");
    probe(108, 66, "R7");
    probe(99, 55, "R7");

    wr(16'h6004, 8'h0B);
    sweep(97, 134, 47, 116, "R5");
    wr(16'h6004, 8'h0E);
    sweep(98, 166, 48, 68, "R5");

    wr(16'h6004, 8'h01);
    sweep(98, 118, 48, 68, "R6");
    wr(16'h6004, 8'h04);
    sweep(98, 118, 48, 68, "R6");

    set_pos(16'h1234, 16'h0300);
    wr(16'h6004, 8'h05);
    sweep(16'h1232, 16'h1246, 16'h02FE, 16'h0312, "R4");

    set_pos(100, 50);
    wr(16'h4100, 8'h07);
    wr(16'h6420, 8'hFF);
    wr(16'h6421, 8'hFF);
    wr(16'h6005, 8'h00);
    wr(16'h6006, 8'h22);
    wr(16'h5000, 8'h09);
    wr(16'h7004, 8'h00);
    sweep(97, 118, 47, 68, "R10");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule